// File: doc/BRIEF.md
# Card Data Word/Byte FIFO Engine

This block sits between a host that moves 32-bit words and a card data port that moves one byte per transfer. It holds a 16-word FIFO. The host first loads a byte length. It then writes a control word that picks the direction and sets enable. In the host-to-card (transmit) direction the host pushes words and the engine unpacks them onto the byte port. In the card-to-host (receive) direction the engine packs incoming bytes into words and the host pops them. In both directions bytes map into a word little-endian: the first byte is bits [7:0] and the fourth is bits [31:24].

A byte counter is loaded from the length when a transfer starts and falls by one for every byte moved on the card port. When the counter reaches zero the engine raises the end flags. A partly filled receive word is flushed into the FIFO at that point. Once the FIFO has also drained, the engine clears its own enable. While a transfer is running, the status vector shows level flags for the active direction only.

All four data paths are valid/ready streams, and a beat moves on a clock edge where both valid and ready are high. `hw_ready` drops only when the FIFO is full. `hr_valid` is high only in receive mode with a word in the FIFO. `crd_in_ready` drops when the FIFO is full, the counter is zero, or the engine is not enabled for receive. `crd_out_valid` is high only in transmit mode while bytes remain and a byte is on hand.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset, `stat` is 0, `xfer_en` is 0, `fifo_words` is 0, `hr_valid` is 0, `hr_data` is 0, and both card stream handshakes are low.
- R2: A cycle with `ctrl_wr` and `ctrl_en` high loads the byte counter from the held length. `fifo_words` always equals (counter + 3) >> 2.
- R3: In transmit mode (`ctrl_rx`=0), each FIFO word leaves on `crd_out_data` lowest byte first, one byte per handshake. Sending stops when the counter reaches zero, and any unsent bytes of the last word are discarded.
- R4: In receive mode (`ctrl_rx`=1), a byte is accepted only while `crd_in_valid` is high, the counter is nonzero and the FIFO is not full. Bytes 0..3 of each group of four fill bits [7:0], [15:8], [23:16] and [31:24] of one FIFO word.
- R5: In receive mode, when the counter reaches zero part way through a word, that word is pushed with its unfilled upper bytes zero.
- R6: `stat` bit 8 (data end) and bit 10 (block end) are set together when the counter reaches zero, or at once when a transfer is enabled with length 0. Both stay set until a transfer with a nonzero length is enabled.
- R7: Once the counter is zero and the FIFO is empty, `xfer_en` clears on the next edge. Whenever the engine is idle or drained, `stat` bits 21..12 read zero.
- R8: While a transfer is active, `stat` shows only its own direction's group. Transmit uses bits 12 active, 14 half-empty, 16 full, 18 empty and 20 data-available. Receive uses bits 13 active, 15 half-full, 17 full, 19 empty and 21 data-available.
- R9: Half-empty means level ≤ 8, half-full means level ≥ 8, full means level 16, empty means level 0, and data-available means level ≠ 0.
- R10: A host push while the counter is zero is discarded. When the FIFO is empty, `hr_valid` is 0 and `hr_data` reads 0.
- R11: A host push into a full FIFO is refused (`hw_ready`=0) and leaves the stored words intact. The FIFO pointers wrap modulo 16, so the word order is kept across the wrap.
- R12: At most one of `crd_in_ready` and `crd_out_valid` is high at a time, matching the selected direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_wr | input | 1 | Load the byte length register |
| len_data | input | 16 | Byte length of the next transfer |
| ctrl_wr | input | 1 | Write control: enable and direction |
| ctrl_en | input | 1 | Enable bit of the control write; 1 starts a transfer |
| ctrl_rx | input | 1 | Direction: 1 card-to-host, 0 host-to-card |
| hw_valid | input | 1 | Host push word valid |
| hw_data | input | 32 | Host push word |
| hw_ready | output | 1 | FIFO can take a host word |
| hr_valid | output | 1 | Receive word available for the host |
| hr_data | output | 32 | FIFO head word, 0 when empty |
| hr_ready | input | 1 | Host pops the head word |
| crd_in_valid | input | 1 | Card has a byte ready |
| crd_in_data | input | 8 | Byte from the card |
| crd_in_ready | output | 1 | Engine takes the card byte |
| crd_out_valid | output | 1 | Byte for the card available |
| crd_out_data | output | 8 | Byte to the card |
| crd_out_ready | input | 1 | Card takes the byte |
| xfer_en | output | 1 | Transfer enable, self-clearing |
| stat | output | 22 | Status flags (bits 8, 10, 12..21) |
| fifo_words | output | 15 | Remaining bytes rounded up to whole words |

## Verification
Transmit is driven with a 6-byte length across two pushed words. Byte order shows whether unpacking is low-byte-first, and the two trailing bytes test whether leftover bytes are dropped. Receive is run with a 6-byte length, which separates full-word packing from the zero-padded flush of a partial word. A 72-byte receive overfills the 16-word FIFO, testing that the card sees back-pressure, that pointer wrap keeps word order, and that refills happen as the host pops. A transmit that loads exactly 8, 9, 16 and then 17 words checks the half and full boundaries and the refused push. A zero-length start checks the immediate end flags and self-disable.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
  localparam int STAT_W      = 22;
  localparam int BIT_DEND    = 8;
  localparam int BIT_BEND    = 10;
  localparam int BIT_TX_ACT  = 12;
  localparam int BIT_RX_ACT  = 13;
  localparam int BIT_TX_HALF = 14;
  localparam int BIT_RX_HALF = 15;
  localparam int BIT_TX_FULL = 16;
  localparam int BIT_RX_FULL = 17;
  localparam int BIT_TX_EMPT = 18;
  localparam int BIT_RX_EMPT = 19;
  localparam int BIT_TX_AVL  = 20;
  localparam int BIT_RX_AVL  = 21;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
endpackage

// File: rtl/cfe_word_fifo.sv
module cfe_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/cfe_rx_pack.sv
module cfe_rx_pack #(
  parameter int W     = 32,
  localparam int LANES = W / 8,
  localparam int IW    = $clog2(LANES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         active,
  input  logic         last,
  input  logic         fifo_full,
  input  logic         in_valid,
  input  logic [7:0]   in_data,
  output logic         in_ready,
  output logic         take,
  output logic         push,
  output logic [W-1:0] push_data
);
  logic [W-1:0]  acc;
  logic [IW-1:0] idx;

  assign in_ready  = active && !fifo_full;
  assign take      = in_ready && in_valid;
  assign push_data = acc | ({{(W-8){1'b0}}, in_data} << {idx, 3'b000});
  assign push      = take && ((idx == IW'(LANES-1)) || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      idx <= '0;
    end else if (clr) begin
      acc <= '0;
      idx <= '0;
    end else if (take) begin
      if (push) begin
        acc <= '0;
        idx <= '0;
      end else begin
        acc <= push_data;
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfe_tx_unpack.sv
module cfe_tx_unpack #(
  parameter int W     = 32,
  localparam int LANES = W / 8,
  localparam int CW    = $clog2(LANES) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         active,
  input  logic         fifo_empty,
  input  logic [W-1:0] head,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [7:0]   out_data,
  output logic         take,
  output logic         pop
);
  logic [W-1:0]  sh;
  logic [CW-1:0] left;
  logic          have;

  assign have      = (left != '0);
  assign out_valid = active && (have || !fifo_empty);
  assign out_data  = have ? sh[7:0] : head[7:0];
  assign take      = out_valid && out_ready;
  assign pop       = take && !have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (flush) begin
      left <= '0;
    end else if (take) begin
      if (have) begin
        sh   <= sh >> 8;
        left <= left - 1'b1;
      end else begin
        sh   <= head >> 8;
        left <= CW'(LANES - 1);
      end
    end
  end
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
  import card_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16,
  localparam int LW    = $clog2(DEPTH) + 1,
  localparam int HALF  = DEPTH / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_wr,
  input  logic [LEN_W-1:0]   len_data,
  input  logic               ctrl_wr,
  input  logic               ctrl_en,
  input  logic               ctrl_rx,
  input  logic               hw_valid,
  input  logic [WORD_W-1:0]  hw_data,
  output logic               hw_ready,
  output logic               hr_valid,
  output logic [WORD_W-1:0]  hr_data,
  input  logic               hr_ready,
  input  logic               crd_in_valid,
  input  logic [7:0]         crd_in_data,
  output logic               crd_in_ready,
  output logic               crd_out_valid,
  output logic [7:0]         crd_out_data,
  input  logic               crd_out_ready,
  output logic               xfer_en,
  output logic [STAT_W-1:0]  stat,
  output logic [LEN_W-2:0]   fifo_words
);
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              en_q, end_q;
  dir_e              dir_q;
  logic              start, cnt_nz, last, byte_take, drained;
  logic              rx_active, tx_active;
  logic              rx_take, rx_push, tx_take, tx_pop;
  logic [WORD_W-1:0] rx_word, head;
  logic              host_push, host_pop;
  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] f_wdata;
  logic [LW-1:0]     fifo_level;

  assign start     = ctrl_wr && ctrl_en;
  assign cnt_nz    = (cnt_q != '0);
  assign last      = (cnt_q == LEN_W'(1));
  assign rx_active = en_q && (dir_q == DIR_RX) && cnt_nz;
  assign tx_active = en_q && (dir_q == DIR_TX) && cnt_nz;
  assign byte_take = rx_take || tx_take;
  assign drained   = !cnt_nz && f_empty;

  // host side
  assign hw_ready  = !f_full;
  assign host_push = hw_valid && hw_ready && cnt_nz && (dir_q == DIR_TX);
  assign hr_valid  = (dir_q == DIR_RX) && !f_empty;
  assign hr_data   = f_empty ? '0 : head;
  assign host_pop  = hr_valid && hr_ready;

  assign f_push  = (dir_q == DIR_RX) ? rx_push : host_push;
  assign f_wdata = (dir_q == DIR_RX) ? rx_word : hw_data;
  assign f_pop   = (dir_q == DIR_RX) ? host_pop : tx_pop;

  cfe_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .push_data(f_wdata),
    .pop(f_pop), .head(head), .level(fifo_level), .full(f_full), .empty(f_empty)
  );

  cfe_rx_pack #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(start), .active(rx_active), .last(last),
    .fifo_full(f_full), .in_valid(crd_in_valid), .in_data(crd_in_data),
    .in_ready(crd_in_ready), .take(rx_take), .push(rx_push), .push_data(rx_word)
  );

  cfe_tx_unpack #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(start || (tx_take && last)),
    .active(tx_active), .fifo_empty(f_empty), .head(head),
    .out_ready(crd_out_ready), .out_valid(crd_out_valid),
    .out_data(crd_out_data), .take(tx_take), .pop(tx_pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      end_q <= 1'b0;
      dir_q <= DIR_TX;
    end else begin
      if (len_wr) len_q <= len_data;
      if (start) begin
        cnt_q <= len_q;
        end_q <= (len_q == '0);
      end else if (byte_take) begin
        cnt_q <= cnt_q - 1'b1;
        if (last) end_q <= 1'b1;
      end
      if (ctrl_wr) begin
        en_q  <= ctrl_en;
        dir_q <= dir_e'(ctrl_rx);
      end else if (en_q && drained) begin
        en_q <= 1'b0;
      end
    end
  end

  assign xfer_en    = en_q;
  assign fifo_words = cnt_q[LEN_W-1:2] + (LEN_W-1)'(|cnt_q[1:0]);

  always_comb begin
    stat           = '0;
    stat[BIT_DEND] = end_q;
    stat[BIT_BEND] = end_q;
    if (en_q && !drained) begin
      if (dir_q == DIR_RX) begin
        stat[BIT_RX_ACT]  = 1'b1;
        stat[BIT_RX_HALF] = (fifo_level >= LW'(HALF));
        stat[BIT_RX_FULL] = f_full;
        stat[BIT_RX_EMPT] = f_empty;
        stat[BIT_RX_AVL]  = !f_empty;
      end else begin
        stat[BIT_TX_ACT]  = 1'b1;
        stat[BIT_TX_HALF] = (fifo_level <= LW'(HALF));
        stat[BIT_TX_FULL] = f_full;
        stat[BIT_TX_EMPT] = f_empty;
        stat[BIT_TX_AVL]  = !f_empty;
      end
    end
  end
endmodule

// File: rtl/card_fifo_engine_chk.sv
module card_fifo_engine_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5,
  parameter int SW    = 22,
  parameter int FW    = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          hw_ready,
  input logic          hr_valid,
  input logic [31:0]   hr_data,
  input logic          crd_in_ready,
  input logic          crd_out_valid,
  input logic          xfer_en,
  input logic [SW-1:0] stat,
  input logic [FW-1:0] fifo_words,
  input logic [LW-1:0] fifo_level
);
  // R7
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |-> (stat[21:12] == '0));
  // R8
  one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[12] && stat[13]));
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == LW'(DEPTH)) |-> !hw_ready);
  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> (fifo_words <= $past(fifo_words)));
  // R3
  send_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crd_out_valid |-> (fifo_words != '0));
  // R10
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |-> (!hr_valid && hr_data == '0));
  // R12
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crd_in_ready, crd_out_valid}));
endmodule

bind card_fifo_engine card_fifo_engine_chk #(
  .DEPTH(DEPTH), .LW(LW), .SW(card_fifo_pkg::STAT_W), .FW(LEN_W-1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .hw_ready(hw_ready),
  .hr_valid(hr_valid), .hr_data(hr_data), .crd_in_ready(crd_in_ready),
  .crd_out_valid(crd_out_valid), .xfer_en(xfer_en), .stat(stat),
  .fifo_words(fifo_words), .fifo_level(fifo_level)
);

// File: tb/test_card_fifo_engine.sv
`timescale 1ns/1ps
module test_card_fifo_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_wr = 0, ctrl_wr = 0, ctrl_en = 0, ctrl_rx = 0;
  logic [15:0] len_data = 0;
  logic        hw_valid = 0, hr_ready = 0, crd_in_valid = 0, crd_out_ready = 0;
  logic [31:0] hw_data = 0;
  logic [7:0]  crd_in_data = 0;
  logic        hw_ready, hr_valid, crd_in_ready, crd_out_valid, xfer_en;
  logic [31:0] hr_data;
  logic [7:0]  crd_out_data;
  logic [21:0] stat;
  logic [14:0] fifo_words;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  card_fifo_engine i_card_fifo_engine (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_data(len_data),
    .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .ctrl_rx(ctrl_rx),
    .hw_valid(hw_valid), .hw_data(hw_data), .hw_ready(hw_ready),
    .hr_valid(hr_valid), .hr_data(hr_data), .hr_ready(hr_ready),
    .crd_in_valid(crd_in_valid), .crd_in_data(crd_in_data), .crd_in_ready(crd_in_ready),
    .crd_out_valid(crd_out_valid), .crd_out_data(crd_out_data), .crd_out_ready(crd_out_ready),
    .xfer_en(xfer_en), .stat(stat), .fifo_words(fifo_words)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_len(int n);
    len_wr = 1; len_data = 16'(n); step(); len_wr = 0;
  endtask

  task automatic go(logic rx);
    ctrl_wr = 1; ctrl_en = 1; ctrl_rx = rx; step(); ctrl_wr = 0;
  endtask

  task automatic push(logic [31:0] w);
    hw_valid = 1; hw_data = w; step(); hw_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 stat", 32'(stat), 0);
    chk("R1 xfer_en", 32'(xfer_en), 0);
    chk("R1 fifo_words", 32'(fifo_words), 0);
    chk("R1 hr_valid/hr_data", {31'(hr_data), hr_valid}, 0);
    chk("R1 card handshakes", {30'd0, crd_in_ready, crd_out_valid}, 0);
  endtask

  task automatic t_tx_short();
    logic [7:0] got [8];
    int n = 0;
    set_len(6);
    go(1'b0);
    chk("R2 words after start", 32'(fifo_words), 2);
    chk("R8 tx empty flags", 32'(stat), 32'h45000);
    push(32'h44332211);
    push(32'h88776655);
    chk("R9 tx level 2 flags", 32'(stat), 32'h105000);
    crd_out_ready = 1;
    for (int c = 0; c < 12; c++) begin
      if (crd_out_valid && n < 8) begin got[n] = crd_out_data; n++; end
      step();
    end
    crd_out_ready = 0;
    chk("R3 byte count", 32'(n), 6);
    for (int i = 0; i < 6; i++) chk("R3 byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));
    chk("R6/R7 end flags only", 32'(stat), 32'h500);
    chk("R7 self disable", 32'(xfer_en), 0);
    chk("R2 words at end", 32'(fifo_words), 0);
  endtask

  task automatic t_ignore_push();
    push(32'hDEADBEEF);
    set_len(4);
    go(1'b0);
    chk("R10 ignored push left fifo empty", 32'(stat), 32'h45000);
    chk("R10 nothing to send", 32'(crd_out_valid), 0);
    ctrl_wr = 1; ctrl_en = 0; step(); ctrl_wr = 0;
  endtask

  task automatic card_byte(logic [7:0] b);
    crd_in_valid = 1; crd_in_data = b;
    while (!crd_in_ready) step();
    step();
    crd_in_valid = 0;
  endtask

  task automatic t_rx_short();
    set_len(6);
    go(1'b1);
    chk("R8 rx empty flags", 32'(stat), 32'h82000);
    for (int i = 0; i < 6; i++) card_byte(8'hA1 + 8'(i));
    chk("R6 rx end with level 2", 32'(stat), 32'h202500);
    chk("R2 words zero", 32'(fifo_words), 0);
    chk("R4 first word", hr_data, 32'hA4A3A2A1);
    chk("R4 hr_valid", 32'(hr_valid), 1);
    hr_ready = 1; step();
    chk("R5 partial word", hr_data, 32'h0000A6A5);
    step(); hr_ready = 0;
    step();
    chk("R7 rx self disable", 32'(xfer_en), 0);
    chk("R10 empty read zero", {hr_data[30:0], hr_valid}, 0);
    chk("R7 rx flags cleared", 32'(stat), 32'h500);
  endtask

  task automatic t_rx_full();
    int k = 0;
    int nw = 0;
    logic [31:0] words [18];
    set_len(72);
    go(1'b1);
    chk("R6 end cleared on start", 32'(stat[10:8]), 0);
    crd_in_valid = 1; crd_in_data = 0;
    for (int c = 0; c < 260 && nw < 18; c++) begin
      if (c == 90) begin
        chk("R4 bytes taken at full", 32'(k), 64);
        chk("R4 card back-pressured", 32'(crd_in_ready), 0);
        chk("R9 rx full flags", 32'(stat), 32'h22A000);
        chk("R2 words remaining", 32'(fifo_words), 2);
        hr_ready = 1;
      end
      if (hr_valid && hr_ready) begin words[nw] = hr_data; nw++; end
      if (crd_in_valid && crd_in_ready) k++;
      step();
      crd_in_data = 8'(k);
    end
    crd_in_valid = 0; hr_ready = 0;
    step();
    chk("R11 word count", 32'(nw), 18);
    for (int i = 0; i < 18; i++)
      chk("R11 wrap order", words[i], {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    chk("R7 disabled after drain", 32'(xfer_en), 0);
  endtask

  task automatic t_tx_bounds();
    logic [7:0] got [70];
    int n = 0;
    set_len(64);
    go(1'b0);
    for (int i = 0; i < 8; i++) push({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    chk("R9 level 8 half-empty", 32'(stat), 32'h105000);
    push({8'(35), 8'(34), 8'(33), 8'(32)});
    chk("R9 level 9", 32'(stat), 32'h101000);
    for (int i = 9; i < 16; i++) push({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    chk("R9 tx full flags", 32'(stat), 32'h111000);
    chk("R11 hw_ready low when full", 32'(hw_ready), 0);
    push(32'hFFFFFFFF);
    crd_out_ready = 1;
    for (int c = 0; c < 80; c++) begin
      if (crd_out_valid && n < 70) begin got[n] = crd_out_data; n++; end
      step();
    end
    crd_out_ready = 0;
    chk("R11 refused push not sent", 32'(n), 64);
    for (int j = 0; j < 64; j++) chk("R3 stream byte", 32'(got[j]), 32'(j));
    chk("R7 tx bounds done", 32'(stat), 32'h500);
  endtask

  task automatic t_zero_len();
    set_len(0);
    go(1'b0);
    chk("R6 zero length end flags", 32'(stat), 32'h500);
    step();
    chk("R7 zero length disable", 32'(xfer_en), 0);
    chk("R12 no handshakes", {30'd0, crd_in_ready, crd_out_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    step();
    rst_n = 1;
    step();
    t_reset();
    t_tx_short();
    t_ignore_push();
    t_rx_short();
    t_rx_full();
    t_tx_bounds();
    t_zero_len();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule